// File: doc/BRIEF.md
# Oversampling Serial Receiver with Noise and Framing Flags

This block recovers asynchronous serial frames from one receive line. An external sample-enable pulse sets the oversampling rate. Each bit period spans 16 of those pulses, or 8 when the rate-select input is high. Only the three samples around the centre of each bit decide its level. By default a two-of-three vote decides. A second mode input makes the centre sample alone decide. The word holds 8 or 9 data bits and is received least significant bit first. The frame is bounded by a low start bit and a high stop bit. The receive line passes through a two-stage synchronizer before any sample is taken.

A received word leaves on a valid/ready stream together with two per-frame flags. The noise flag is set when the three centre samples of any bit in the frame disagree. The framing flag is set when the stop bit reads low.

Back-pressure rules:
- `out_valid` stays high, and the word and flags stay unchanged, until a cycle with `out_ready` high.
- `out_valid` falls in the cycle after that handshake.
- The receiver never stalls. A frame that completes while an earlier word is still waiting replaces that word.

The configuration inputs (`over8`, `one_samp`, `len9`) are captured when a start edge is detected and hold for the whole frame.

Top module: `osr_uart_rx`

## Requirements
- R1: With `over8` = 0 a bit lasts 16 sample pulses; with `over8` = 1 it lasts 8. Sample 0 of the start bit is the first pulse at which the synchronized line is seen low while idle.
- R2: With `one_samp` = 0 each bit takes the majority of its samples N/2-1, N/2 and N/2+1, where N is the samples per bit.
- R3: With `one_samp` = 1 each bit takes sample N/2 only, and the other two centre samples do not affect the value.
- R4: `out_noise` is 1 for a frame when the three centre samples of its start, data or stop bit are not all equal, in either decision mode. Samples outside the centre three never set it.
- R5: With `len9` = 0 the word has 8 data bits and `out_data[8]` is 0. With `len9` = 1 it has 9. The first data bit received lands in `out_data[0]`.
- R6: If the decided level of the start bit is high, the receiver drops back to idle and delivers no word.
- R7: If the stop bit decides low, the word is still delivered, with `out_ferr` = 1. Otherwise `out_ferr` = 0.
- R8: `out_valid` holds with the word stable until `out_ready` is high. It falls in the cycle after the handshake. A newer frame overwrites a word that has not been taken.
- R9: After reset `out_valid` is 0 and the receiver is idle. A reset in the middle of a frame leaves no partial word.
- R10: The receiver's state and sample position advance only on cycles where `samp_en` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_in | input | 1 | Asynchronous serial receive line, idle high |
| samp_en | input | 1 | Oversampling pulse, one cycle per sample |
| over8 | input | 1 | 0: 16 samples per bit, 1: 8 samples per bit |
| one_samp | input | 1 | 0: three-sample vote, 1: centre sample only |
| len9 | input | 1 | 0: 8 data bits, 1: 9 data bits |
| out_ready | input | 1 | Downstream accepts the word |
| out_valid | output | 1 | A received word is waiting |
| out_data | output | 9 | Received word, first bit in bit 0 |
| out_noise | output | 1 | Centre samples disagreed in this frame |
| out_ferr | output | 1 | Stop bit was read low |

## Verification
The bench builds the block with its default parameters: at most 16 samples per bit, a word of up to 9 bits and two synchronizer stages. These defaults reach both oversampling ratios and both word lengths through the mode inputs alone. Single-sample disturbances are placed inside and outside the centre window of start, data and stop bits, so that the vote, the single-sample choice and the noise flag can be told apart. Further directed cases cover a short start glitch, a low stop bit, a stalled consumer that is overrun by a second frame, a long low line held without sample pulses, and a reset in the middle of a frame.

// File: rtl/osr_rx_pkg.sv
package osr_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_e;

endpackage

// File: rtl/osr_rx_sync.sv
module osr_rx_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) q[i] <= RESET_VAL;
        else     q[i] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) q[i] <= RESET_VAL;
        else     q[i] <= q[i-1];
      end
    end
  end

  assign dout = q[STAGES-1];

endmodule

// File: rtl/osr_rx_vote.sv
module osr_rx_vote #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          samp_en,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] centre,
  input  logic          rx_s,
  input  logic          one_samp,
  output logic          bit_val,
  output logic          noisy
);

  // Early and centre samples are held; the late one is the live sample.
  logic s_early, s_mid;
  logic maj;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_early <= 1'b1;
      s_mid   <= 1'b1;
    end else if (samp_en) begin
      if (cnt == centre - 1'b1) s_early <= rx_s;
      if (cnt == centre)        s_mid   <= rx_s;
    end
  end

  always_comb begin
    maj     = (s_early & s_mid) | (s_early & rx_s) | (s_mid & rx_s);
    bit_val = one_samp ? s_mid : maj;
    noisy   = (s_early != s_mid) || (s_mid != rx_s);
  end

endmodule

// File: rtl/osr_rx_ctrl.sv
module osr_rx_ctrl
  import osr_rx_pkg::*;
#(
  parameter int unsigned OSR_MAX  = 16,
  parameter int unsigned WORD_MAX = 9,
  parameter int unsigned CW       = $clog2(OSR_MAX),
  parameter int unsigned BW       = $clog2(WORD_MAX + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                samp_en,
  input  logic                rx_s,
  input  logic                over8,
  input  logic                one_samp,
  input  logic                len9,
  input  logic                bit_val,
  input  logic                noisy,
  output logic [CW-1:0]       cnt,
  output logic [CW-1:0]       centre,
  output logic                cfg_o8,
  output logic                cfg_one,
  output rx_state_e           state,
  output logic                frame_done,
  output logic [WORD_MAX-1:0] frame_word,
  output logic                frame_noise,
  output logic                frame_ferr
);

  localparam logic [CW-1:0] LAST_WIDE = CW'(OSR_MAX - 1);
  localparam logic [CW-1:0] LAST_NARR = CW'(OSR_MAX / 2 - 1);
  localparam logic [CW-1:0] MID_WIDE  = CW'(OSR_MAX / 2);
  localparam logic [CW-1:0] MID_NARR  = CW'(OSR_MAX / 4);
  localparam logic [BW-1:0] TOP_LONG  = BW'(WORD_MAX - 1);
  localparam logic [BW-1:0] TOP_SHORT = BW'(WORD_MAX - 2);

  logic                cfg_l9;
  logic [BW-1:0]       bit_idx;
  logic [WORD_MAX-1:0] shreg;
  logic                noise_acc;
  logic [CW-1:0]       last_cnt;
  logic [CW-1:0]       cnt_nxt;
  logic [BW-1:0]       top_bit;
  logic                decide;
  logic                wrap;

  always_comb begin
    last_cnt = cfg_o8 ? LAST_NARR : LAST_WIDE;
    centre   = cfg_o8 ? MID_NARR  : MID_WIDE;
    top_bit  = cfg_l9 ? TOP_LONG  : TOP_SHORT;
    decide   = (cnt == centre + 1'b1);
    wrap     = (cnt == last_cnt);
    cnt_nxt  = wrap ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      bit_idx     <= '0;
      shreg       <= '0;
      noise_acc   <= 1'b0;
      cfg_o8      <= 1'b0;
      cfg_one     <= 1'b0;
      cfg_l9      <= 1'b0;
      frame_done  <= 1'b0;
      frame_word  <= '0;
      frame_noise <= 1'b0;
      frame_ferr  <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (samp_en) begin
        unique case (state)
          ST_IDLE: begin
            if (!rx_s) begin
              state     <= ST_START;
              cnt       <= CW'(1);
              bit_idx   <= '0;
              shreg     <= '0;
              noise_acc <= 1'b0;
              cfg_o8    <= over8;
              cfg_one   <= one_samp;
              cfg_l9    <= len9;
            end
          end
          ST_START: begin
            cnt <= cnt_nxt;
            if (decide && bit_val) begin
              state <= ST_IDLE;
              cnt   <= '0;
            end else begin
              if (decide) noise_acc <= noise_acc | noisy;
              if (wrap)   state <= ST_DATA;
            end
          end
          ST_DATA: begin
            cnt <= cnt_nxt;
            if (decide) begin
              shreg[bit_idx] <= bit_val;
              noise_acc      <= noise_acc | noisy;
            end
            if (wrap) begin
              if (bit_idx == top_bit) state <= ST_STOP;
              else                    bit_idx <= bit_idx + 1'b1;
            end
          end
          ST_STOP: begin
            cnt <= cnt_nxt;
            if (decide) begin
              frame_done  <= 1'b1;
              frame_word  <= shreg;
              frame_noise <= noise_acc | noisy;
              frame_ferr  <= !bit_val;
              state       <= ST_IDLE;
              cnt         <= '0;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/osr_rx_outq.sv
module osr_rx_outq #(
  parameter int unsigned WORD_MAX = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                push,
  input  logic [WORD_MAX-1:0] in_word,
  input  logic                in_noise,
  input  logic                in_ferr,
  input  logic                out_ready,
  output logic                out_valid,
  output logic [WORD_MAX-1:0] out_data,
  output logic                out_noise,
  output logic                out_ferr
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_noise <= 1'b0;
      out_ferr  <= 1'b0;
    end else if (push) begin
      out_valid <= 1'b1;
      out_data  <= in_word;
      out_noise <= in_noise;
      out_ferr  <= in_ferr;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/osr_uart_rx.sv
module osr_uart_rx
  import osr_rx_pkg::*;
#(
  parameter int unsigned OSR_MAX     = 16,
  parameter int unsigned WORD_MAX    = 9,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rx_in,
  input  logic                samp_en,
  input  logic                over8,
  input  logic                one_samp,
  input  logic                len9,
  input  logic                out_ready,
  output logic                out_valid,
  output logic [WORD_MAX-1:0] out_data,
  output logic                out_noise,
  output logic                out_ferr
);

  localparam int unsigned CW = $clog2(OSR_MAX);
  localparam int unsigned BW = $clog2(WORD_MAX + 1);

  logic                rx_s;
  logic [CW-1:0]       rx_cnt;
  logic [CW-1:0]       rx_centre;
  logic                rx_cfg_o8;
  logic                rx_cfg_one;
  rx_state_e           rx_state;
  logic                bit_val;
  logic                noisy;
  logic                frame_done;
  logic [WORD_MAX-1:0] frame_word;
  logic                frame_noise;
  logic                frame_ferr;

  osr_rx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) i_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (rx_in),
    .dout (rx_s)
  );

  osr_rx_vote #(.CW(CW)) i_vote (
    .clk      (clk),
    .rst      (rst),
    .samp_en  (samp_en),
    .cnt      (rx_cnt),
    .centre   (rx_centre),
    .rx_s     (rx_s),
    .one_samp (rx_cfg_one),
    .bit_val  (bit_val),
    .noisy    (noisy)
  );

  osr_rx_ctrl #(.OSR_MAX(OSR_MAX), .WORD_MAX(WORD_MAX), .CW(CW), .BW(BW)) i_ctrl (
    .clk         (clk),
    .rst         (rst),
    .samp_en     (samp_en),
    .rx_s        (rx_s),
    .over8       (over8),
    .one_samp    (one_samp),
    .len9        (len9),
    .bit_val     (bit_val),
    .noisy       (noisy),
    .cnt         (rx_cnt),
    .centre      (rx_centre),
    .cfg_o8      (rx_cfg_o8),
    .cfg_one     (rx_cfg_one),
    .state       (rx_state),
    .frame_done  (frame_done),
    .frame_word  (frame_word),
    .frame_noise (frame_noise),
    .frame_ferr  (frame_ferr)
  );

  osr_rx_outq #(.WORD_MAX(WORD_MAX)) i_outq (
    .clk       (clk),
    .rst       (rst),
    .push      (frame_done),
    .in_word   (frame_word),
    .in_noise  (frame_noise),
    .in_ferr   (frame_ferr),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_noise (out_noise),
    .out_ferr  (out_ferr)
  );

endmodule

// File: rtl/osr_uart_rx_chk.sv
module osr_uart_rx_chk
  import osr_rx_pkg::*;
#(
  parameter int unsigned OSR_MAX  = 16,
  parameter int unsigned WORD_MAX = 9,
  parameter int unsigned CW       = $clog2(OSR_MAX)
) (
  input logic                clk,
  input logic                rst,
  input logic                samp_en,
  input logic                out_ready,
  input logic                out_valid,
  input logic [WORD_MAX-1:0] out_data,
  input logic                frame_done,
  input rx_state_e           rx_state,
  input logic [CW-1:0]       rx_cnt,
  input logic                rx_cfg_o8
);

  assert_hold_stall_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !frame_done) |=> (out_valid && $stable(out_data)));

  assert_drop_after_take_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !frame_done) |=> !out_valid);

  assert_tick_gate_R10: assert property (@(posedge clk) disable iff (rst)
    !samp_en |=> ($stable(rx_state) && $stable(rx_cnt)));

  assert_reset_clear_R9: assert property (@(posedge clk)
    rst |=> !out_valid);

  assert_narrow_range_R1: assert property (@(posedge clk) disable iff (rst)
    (rx_state != ST_IDLE && rx_cfg_o8) |-> (32'(rx_cnt) < OSR_MAX / 2));

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> (rx_state == ST_IDLE));

  assert_push_valid_R8: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> out_valid);

endmodule

bind osr_uart_rx osr_uart_rx_chk #(.OSR_MAX(OSR_MAX), .WORD_MAX(WORD_MAX)) i_chk (
  .clk        (clk),
  .rst        (rst),
  .samp_en    (samp_en),
  .out_ready  (out_ready),
  .out_valid  (out_valid),
  .out_data   (out_data),
  .frame_done (frame_done),
  .rx_state   (rx_state),
  .rx_cnt     (rx_cnt),
  .rx_cfg_o8  (rx_cfg_o8)
);

// File: tb/test_osr_uart_rx.sv
`timescale 1ns/1ps
module test_osr_uart_rx;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_in = 1'b1;
  logic       samp_en = 1'b0;
  logic       over8 = 1'b0;
  logic       one_samp = 1'b0;
  logic       len9 = 1'b0;
  logic       out_ready = 1'b1;
  logic       out_valid;
  logic [8:0] out_data;
  logic       out_noise;
  logic       out_ferr;

  int n_tests = 0;
  int n_fail  = 0;
  bit done_flag = 1'b0;

  int         cap_cnt = 0;
  logic [8:0] cap_data = '0;
  logic       cap_noise = 1'b0;
  logic       cap_ferr = 1'b0;

  always #5 clk = ~clk;

  osr_uart_rx i_osr_uart_rx (
    .clk(clk), .rst(rst), .rx_in(rx_in), .samp_en(samp_en),
    .over8(over8), .one_samp(one_samp), .len9(len9),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .out_noise(out_noise), .out_ferr(out_ferr)
  );

  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) begin
      cap_cnt   = cap_cnt + 1;
      cap_data  = out_data;
      cap_noise = out_noise;
      cap_ferr  = out_ferr;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic sample(input logic lvl);
    rx_in   = lvl;
    samp_en = 1'b0;
    repeat (3) @(negedge clk);
    samp_en = 1'b1;
    @(negedge clk);
    samp_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) sample(1'b1);
  endtask

  // Drives one frame; a single sample may be inverted (fen, bit fb, sample fs).
  task automatic send_frame(input logic o8, input logic one, input logic l9,
                            input logic [8:0] din, input int fb, input int fs,
                            input logic fen, input logic stop);
    int n, nb;
    logic lvl;
    over8 = o8; one_samp = one; len9 = l9;
    n  = o8 ? 8 : 16;
    nb = l9 ? 9 : 8;
    for (int b = 0; b <= nb + 1; b++) begin
      for (int s = 0; s < n; s++) begin
        if (b == 0)       lvl = 1'b0;
        else if (b <= nb) lvl = din[b-1];
        else              lvl = (s > n / 2 + 1) ? 1'b1 : stop;
        if (fen && fb == b && fs == s) lvl = !lvl;
        sample(lvl);
      end
    end
    idle(4);
  endtask

  // {o8, one, l9, din, flip bit, flip sample, flip en, stop, exp noise, exp ferr, exp data}
  localparam logic [32:0] VEC [12] = '{
    {1'b0, 1'b0, 1'b0, 9'h0A5, 4'd0, 4'd0, 1'b0, 1'b1, 1'b0, 1'b0, 9'h0A5},
    {1'b1, 1'b0, 1'b0, 9'h03C, 4'd0, 4'd0, 1'b0, 1'b1, 1'b0, 1'b0, 9'h03C},
    {1'b0, 1'b0, 1'b1, 9'h1C3, 4'd0, 4'd0, 1'b0, 1'b1, 1'b0, 1'b0, 9'h1C3},
    {1'b1, 1'b0, 1'b1, 9'h155, 4'd0, 4'd0, 1'b0, 1'b1, 1'b0, 1'b0, 9'h155},
    {1'b0, 1'b0, 1'b0, 9'h0F0, 4'd1, 4'd8, 1'b1, 1'b1, 1'b1, 1'b0, 9'h0F0},
    {1'b0, 1'b1, 1'b0, 9'h0F0, 4'd1, 4'd8, 1'b1, 1'b1, 1'b1, 1'b0, 9'h0F1},
    {1'b1, 1'b1, 1'b0, 9'h00F, 4'd2, 4'd3, 1'b1, 1'b1, 1'b1, 1'b0, 9'h00F},
    {1'b1, 1'b0, 1'b0, 9'h081, 4'd3, 4'd0, 1'b1, 1'b1, 1'b0, 1'b0, 9'h081},
    {1'b0, 1'b0, 1'b0, 9'h055, 4'd0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b1, 9'h055},
    {1'b0, 1'b0, 1'b0, 9'h0AA, 4'd0, 4'd9, 1'b1, 1'b1, 1'b1, 1'b0, 9'h0AA},
    {1'b0, 1'b0, 1'b0, 9'h033, 4'd9, 4'd7, 1'b1, 1'b1, 1'b1, 1'b0, 9'h033},
    {1'b1, 1'b1, 1'b1, 9'h100, 4'd0, 4'd0, 1'b0, 1'b1, 1'b0, 1'b0, 9'h100}
  };
  string VTAG [12] = '{"R1_R5", "R1", "R5", "R5", "R2_R4", "R3_R4",
                       "R3_R4", "R4", "R7", "R2_R6", "R4_R7", "R3_R5"};

  task automatic finish_run;
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int c0;
    logic [32:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R9", "valid after reset", out_valid, 0);
    idle(4);

    // Table of frames
    for (int i = 0; i < 12; i++) begin
      v  = VEC[i];
      c0 = cap_cnt;
      send_frame(v[32], v[31], v[30], v[29:21], int'(v[20:17]), int'(v[16:13]),
                 v[12], v[11]);
      check(cap_cnt == c0 + 1, VTAG[i], "frame count", cap_cnt - c0, 1);
      check(cap_data == v[8:0], VTAG[i], "data", cap_data, v[8:0]);
      check(cap_noise == v[10], VTAG[i], "noise", cap_noise, v[10]);
      check(cap_ferr == v[9], VTAG[i], "ferr", cap_ferr, v[9]);
    end

    // R6: start glitch shorter than half a bit is dropped
    over8 = 1'b0; one_samp = 1'b0; len9 = 1'b0;
    c0 = cap_cnt;
    for (int s = 0; s < 3; s++) sample(1'b0);
    idle(20);
    check(cap_cnt == c0, "R6", "glitch frame count", cap_cnt - c0, 0);
    send_frame(1'b0, 1'b0, 1'b0, 9'h05A, 0, 0, 1'b0, 1'b1);
    check(cap_cnt == c0 + 1 && cap_data == 9'h05A, "R6", "frame after glitch",
          cap_data, 9'h05A);

    // R10: line low without sample pulses starts nothing
    c0 = cap_cnt;
    rx_in = 1'b0;
    repeat (300) @(negedge clk);
    rx_in = 1'b1;
    repeat (4) @(negedge clk);
    idle(30);
    check(cap_cnt == c0, "R10", "frames without pulses", cap_cnt - c0, 0);

    // R8: stalled consumer, overwrite, then handshake
    out_ready = 1'b0;
    c0 = cap_cnt;
    send_frame(1'b1, 1'b0, 1'b0, 9'h011, 0, 0, 1'b0, 1'b1);
    repeat (10) @(negedge clk);
    check(out_valid == 1'b1, "R8", "valid held", out_valid, 1);
    check(out_data == 9'h011, "R8", "held data", out_data, 9'h011);
    send_frame(1'b1, 1'b0, 1'b0, 9'h022, 0, 0, 1'b0, 1'b1);
    check(out_valid == 1'b1 && out_data == 9'h022, "R8", "overwritten data",
          out_data, 9'h022);
    out_ready = 1'b1;
    @(negedge clk);
    check(cap_cnt == c0 + 1 && cap_data == 9'h022, "R8", "taken word",
          cap_data, 9'h022);
    @(negedge clk);
    check(out_valid == 1'b0, "R8", "valid after take", out_valid, 0);

    // R9: reset mid-frame leaves nothing, next frame is clean
    c0 = cap_cnt;
    over8 = 1'b0;
    for (int s = 0; s < 40; s++) sample(1'b0);
    rst = 1'b1;
    rx_in = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(4);
    check(cap_cnt == c0 && out_valid == 1'b0, "R9", "no word after reset",
          cap_cnt - c0, 0);
    send_frame(1'b0, 1'b0, 1'b1, 9'h0C9, 0, 0, 1'b0, 1'b1);
    check(cap_cnt == c0 + 1 && cap_data == 9'h0C9, "R9", "frame after reset",
          cap_data, 9'h0C9);

    finish_run();
  end

endmodule